// File: doc/BRIEF.md
# Byte-Lane Strobe Bus Memory Slave

This block is a bus slave that fronts a small local memory on a 16-bit asynchronous-style strobe bus. A master opens an access by pulling the address strobe low and then asserting one or both byte-lane data strobes. The block decodes the word address against one base/size window, serves the selected lanes, and answers with a low-active acknowledge. An access that falls outside the window is answered with a bus-error signal instead, and memory stays untouched.

The acknowledge follows the data strobes, not the address strobe. Each time the data strobes are released and asserted again while the address strobe stays low, the slave treats it as a fresh access. An indivisible read-modify-write sequence therefore works: the read half is served, the slave re-arms, and the write half to the same address is served before the address strobe is ever released. A parameter sets a fixed number of wait cycles (0 to 7) before each response. All bus inputs are taken as synchronous to `clk`.

Top module: `strobe_byte_slave`

## Requirements
- R1: While and just after reset, `ack_n` and `berr_n` are high and `data_oe` is 0; every memory word reads as 0 after reset.
- R2: A read strobe inside the window is acknowledged (`ack_n` low) and the stored byte of each selected lane is driven. `uds_n` selects bits 15:8 (`data_oe[1]`) and `lds_n` selects bits 7:0 (`data_oe[0]`). An unselected lane is not driven.
- R3: A write strobe inside the window stores `data_in` into the selected lane(s) only and leaves the other byte of the word unchanged. It is acknowledged with the same latency as a read.
- R4: When both data strobes go high, `data_oe` drops to 0 in the same cycle without a clock edge, and `ack_n`/`berr_n` are high after the next rising edge.
- R5: With `as_n` held low, a strobe release followed by a new strobe assertion is served as a second access. A read followed by a write to one address returns the old value and then stores the new one.
- R6: An access whose word address lies outside [BASE_WORD, BASE_WORD+MEM_DEPTH) drives `berr_n` low and never `ack_n`. It drives no data and changes no memory.
- R7: `data_oe` is 0 whenever `rd_wr` is 0 (write), and `ack_n` and `berr_n` are never low together.
- R8: A strobe with `func_code` equal to 3'b111 gets neither acknowledge nor bus error, and memory is unchanged.
- R9: With both `uds_n` and `lds_n` low, the full 16-bit word is read or written in one access.
- R10: The response appears after exactly WAIT_CYC+1 rising edges, counted from the first edge that samples the asserted strobe. It is never earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, low active |
| as_n | input | 1 | Address strobe, low active |
| uds_n | input | 1 | Upper byte strobe (bits 15:8), low active |
| lds_n | input | 1 | Lower byte strobe (bits 7:0), low active |
| rd_wr | input | 1 | 1 = read, 0 = write |
| func_code | input | 3 | Access class; 3'b111 is not answered |
| bus_addr | input | ADDR_W | Word address |
| data_in | input | 16 | Write data from master |
| data_out | output | 16 | Read data, zero on undriven lanes |
| data_oe | output | 2 | Per-lane output enable (bit 1 upper, bit 0 lower) |
| ack_n | output | 1 | Transfer acknowledge, low active |
| berr_n | output | 1 | Bus error, low active |

## Verification
Strobes are applied on a falling edge. The response is due WAIT_CYC+2 falling edges later, so the bench counts falling edges until acknowledge or error and compares that count. This also confirms that the response was still absent one edge earlier. The release of the output enables is combinational, so it is checked one time unit after the strobes rise. The negated acknowledge is due one clock later and is checked at the next falling edge. Memory effects are checked through later reads, against a model array kept in the bench.

// File: rtl/strobe_slave_pkg.sv
package strobe_slave_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RESP = 2'd2
    } hs_state_e;

    typedef struct packed {
        hs_state_e  st;
        logic [2:0] cnt;
        logic       is_read;
        logic [1:0] lanes;
        logic       hit;
        logic       ack_n;
        logic       berr_n;
    } hs_regs_t;

    localparam hs_regs_t HS_RESET = '{
        st:      ST_IDLE,
        cnt:     3'd0,
        is_read: 1'b1,
        lanes:   2'b00,
        hit:     1'b0,
        ack_n:   1'b1,
        berr_n:  1'b1
    };

endpackage

// File: rtl/ss_window_dec.sv
module ss_window_dec #(
    parameter int          ADDR_W    = 23,
    parameter int unsigned BASE_WORD = 32'h100,
    parameter int unsigned DEPTH     = 16,
    parameter int          IDX_W     = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W:0] BASE_X  = (ADDR_W+1)'(BASE_WORD);
    localparam logic [ADDR_W:0] DEPTH_X = (ADDR_W+1)'(DEPTH);

    logic [ADDR_W:0] addr_x;
    logic [ADDR_W:0] offset;

    always_comb begin
        addr_x = {1'b0, addr};
        offset = addr_x - BASE_X;
        hit    = (addr_x >= BASE_X) && (offset < DEPTH_X);
        idx    = offset[IDX_W-1:0];
    end
endmodule

// File: rtl/ss_lane_mem.sv
module ss_lane_mem #(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4,
    parameter int LANES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [LANES-1:0]   lanes,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [LANES*8-1:0] wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [LANES*8-1:0] rd_data
);
    logic [LANES*8-1:0] mem_q [DEPTH];
    logic [LANES*8-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        for (int l = 0; l < LANES; l++) begin
            if (we && lanes[l]) begin
                mem_d[wr_idx][l*8 +: 8] = wr_data[l*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_rd_lane
        assign rd_data[g*8 +: 8] = mem_q[rd_idx][g*8 +: 8];
    end
endmodule

// File: rtl/ss_hs_ctrl.sv
module ss_hs_ctrl
    import strobe_slave_pkg::*;
#(
    parameter int WAIT_CYC = 2,
    parameter int IDX_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_act,
    input  logic             rd_wr,
    input  logic [1:0]       lanes_in,
    input  logic             hit_in,
    input  logic [IDX_W-1:0] idx_in,
    output logic             ack_n,
    output logic             berr_n,
    output logic             resp_read,
    output logic [1:0]       lanes_q,
    output logic [IDX_W-1:0] idx_q,
    output logic             mem_we
);
    localparam logic [2:0] WAIT_INIT = 3'(WAIT_CYC);

    hs_regs_t         r_d, r_q;
    logic [IDX_W-1:0] idx_d, idx_r;

    always_comb begin
        r_d    = r_q;
        idx_d  = idx_r;
        mem_we = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (stb_act) begin
                    r_d.st      = ST_WAIT;
                    r_d.cnt     = WAIT_INIT;
                    r_d.is_read = rd_wr;
                    r_d.lanes   = lanes_in;
                    r_d.hit     = hit_in;
                    idx_d       = idx_in;
                end
            end
            ST_WAIT: begin
                if (!stb_act) begin
                    r_d.st = ST_IDLE;
                end else if (r_q.cnt == 3'd0) begin
                    r_d.st = ST_RESP;
                    if (r_q.hit) begin
                        r_d.ack_n = 1'b0;
                        mem_we    = !r_q.is_read;
                    end else begin
                        r_d.berr_n = 1'b0;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - 3'd1;
                end
            end
            ST_RESP: begin
                if (!stb_act) begin
                    r_d.st     = ST_IDLE;
                    r_d.ack_n  = 1'b1;
                    r_d.berr_n = 1'b1;
                end
            end
            default: r_d = HS_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q   <= HS_RESET;
            idx_r <= '0;
        end else begin
            r_q   <= r_d;
            idx_r <= idx_d;
        end
    end

    assign ack_n     = r_q.ack_n;
    assign berr_n    = r_q.berr_n;
    assign resp_read = (r_q.st == ST_RESP) && r_q.is_read && r_q.hit;
    assign lanes_q   = r_q.lanes;
    assign idx_q     = idx_r;
endmodule

// File: rtl/strobe_byte_slave.sv
module strobe_byte_slave #(
    parameter int          ADDR_W    = 23,
    parameter int unsigned MEM_DEPTH = 16,
    parameter int unsigned BASE_WORD = 32'h100,
    parameter int          WAIT_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_n,
    input  logic              uds_n,
    input  logic              lds_n,
    input  logic              rd_wr,
    input  logic [2:0]        func_code,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       data_in,
    output logic [15:0]       data_out,
    output logic [1:0]        data_oe,
    output logic              ack_n,
    output logic              berr_n
);
    localparam int         IDX_W   = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1;
    localparam int         LANES   = 2;
    localparam logic [2:0] FC_SKIP = 3'b111;

    logic [LANES-1:0] lanes_now;
    logic             stb_act;
    logic             hit;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] idx_q;
    logic [LANES-1:0] lanes_q;
    logic             resp_read;
    logic             mem_we;
    logic [15:0]      rd_data;

    assign lanes_now = {!uds_n, !lds_n};
    assign stb_act   = !as_n && (lanes_now != 2'b00) && (func_code != FC_SKIP);

    ss_window_dec #(
        .ADDR_W   (ADDR_W),
        .BASE_WORD(BASE_WORD),
        .DEPTH    (MEM_DEPTH),
        .IDX_W    (IDX_W)
    ) dec_i (
        .addr(bus_addr),
        .hit (hit),
        .idx (idx)
    );

    ss_hs_ctrl #(
        .WAIT_CYC(WAIT_CYC),
        .IDX_W   (IDX_W)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb_act  (stb_act),
        .rd_wr    (rd_wr),
        .lanes_in (lanes_now),
        .hit_in   (hit),
        .idx_in   (idx),
        .ack_n    (ack_n),
        .berr_n   (berr_n),
        .resp_read(resp_read),
        .lanes_q  (lanes_q),
        .idx_q    (idx_q),
        .mem_we   (mem_we)
    );

    ss_lane_mem #(
        .DEPTH(MEM_DEPTH),
        .IDX_W(IDX_W),
        .LANES(LANES)
    ) mem_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (mem_we),
        .lanes  (lanes_q),
        .wr_idx (idx_q),
        .wr_data(data_in),
        .rd_idx (idx_q),
        .rd_data(rd_data)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_out_lane
        assign data_oe[g] = resp_read && lanes_q[g] && lanes_now[g] && rd_wr && !as_n;
        assign data_out[g*8 +: 8] = data_oe[g] ? rd_data[g*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/strobe_byte_slave_chk.sv
module strobe_byte_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       as_n,
    input logic       uds_n,
    input logic       lds_n,
    input logic       rd_wr,
    input logic [2:0] func_code,
    input logic [1:0] data_oe,
    input logic       ack_n,
    input logic       berr_n
);
    logic stb_seen;
    assign stb_seen = !as_n && (!uds_n || !lds_n) && (func_code != 3'b111);

    // R1: responses idle right after a reset cycle
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (ack_n && berr_n));

    // R4: strobes absent at an edge -> no response after it
    a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_seen |=> (ack_n && berr_n));

    // R7: never drive data during a write
    a_r7_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_wr |-> (data_oe == 2'b00));

    // R7: acknowledge and error exclusive
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ack_n && !berr_n));

    // R10: a new acknowledge needs a strobe sampled on the previous edge
    a_r10_ack_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n) |-> $past(stb_seen));

    // R2: driven data only together with acknowledge
    a_r2_drive_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe != 2'b00) |-> !ack_n);

    // R6: bus error holds no data on the lanes
    a_r6_err_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !berr_n |-> (data_oe == 2'b00));
endmodule

bind strobe_byte_slave strobe_byte_slave_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .as_n     (as_n),
    .uds_n    (uds_n),
    .lds_n    (lds_n),
    .rd_wr    (rd_wr),
    .func_code(func_code),
    .data_oe  (data_oe),
    .ack_n    (ack_n),
    .berr_n   (berr_n)
);

// File: tb/strobe_byte_slave_tb_top.sv
module strobe_byte_slave_tb_top;
    localparam int ADDR_W = 23;
    localparam int DEPTH  = 16;
    localparam int BASE   = 'h100;
    localparam int WAITC  = 2;
    localparam int LAT    = WAITC + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1, rd_wr = 1'b1;
    logic [2:0]        func_code = 3'b101;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [15:0]       data_in = '0;
    logic [15:0]       data_out;
    logic [1:0]        data_oe;
    logic              ack_n, berr_n;

    int checks = 0;
    int fails  = 0;
    logic [15:0] mdl [DEPTH];

    always #2 clk = ~clk;

    strobe_byte_slave #(
        .ADDR_W(ADDR_W), .MEM_DEPTH(DEPTH), .BASE_WORD(BASE), .WAIT_CYC(WAITC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n),
        .rd_wr(rd_wr), .func_code(func_code), .bus_addr(bus_addr),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .ack_n(ack_n), .berr_n(berr_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int i);
        return 16'(32'h3C5A ^ (i * 32'h0901));
    endfunction

    // one strobe access starting at a falling edge
    task automatic access(input logic rw, input int a, input logic ud, input logic ld,
                          input logic [15:0] wd, input logic hold_as, input string req,
                          output logic [15:0] rd, output logic [1:0] oe,
                          output logic got_ack, output logic got_err, output int lat);
        as_n = 1'b0; rd_wr = rw; bus_addr = ADDR_W'(a); data_in = wd;
        uds_n = !ud; lds_n = !ld;
        lat = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            lat++;
            if (!ack_n || !berr_n) break;
        end
        got_ack = !ack_n; got_err = !berr_n; rd = data_out; oe = data_oe;
        if (!rw) chk(oe == 2'b00, "R7", "oe during write", 32'(oe), 0);
        chk(!(got_ack && got_err), "R7", "ack and berr together", 32'({got_ack, got_err}), 0);
        uds_n = 1'b1; lds_n = 1'b1;
        #1;
        chk(data_oe == 2'b00, "R4", "oe after strobe release", 32'(data_oe), 0);
        @(negedge clk);
        chk(ack_n && berr_n, req, "response release R4", 32'({ack_n, berr_n}), 32'h3);
        if (!hold_as) as_n = 1'b1;
        rd_wr = 1'b1;
    endtask

    task automatic do_write(input int i, input logic ud, input logic ld,
                            input logic [15:0] wd, input logic hold_as, input string req);
        logic [15:0] rd; logic [1:0] oe; logic ga, ge; int lat;
        access(1'b0, BASE + i, ud, ld, wd, hold_as, req, rd, oe, ga, ge, lat);
        chk(ga && !ge, req, "write ack", 32'({ga, ge}), 32'h2);
        chk(lat == LAT, "R10", "write latency", 32'(lat), 32'(LAT));
        if (ud) mdl[i][15:8] = wd[15:8];
        if (ld) mdl[i][7:0]  = wd[7:0];
    endtask

    task automatic do_read(input int i, input logic ud, input logic ld,
                           input logic hold_as, input string req);
        logic [15:0] rd; logic [1:0] oe; logic ga, ge; int lat;
        logic [15:0] exp;
        access(1'b1, BASE + i, ud, ld, 16'h0, hold_as, req, rd, oe, ga, ge, lat);
        exp = {ud ? mdl[i][15:8] : 8'h00, ld ? mdl[i][7:0] : 8'h00};
        chk(ga && !ge, req, "read ack", 32'({ga, ge}), 32'h2);
        chk(lat == LAT, "R10", "read latency", 32'(lat), 32'(LAT));
        chk(oe == {ud, ld}, req, "read lane enables", 32'(oe), 32'({ud, ld}));
        chk(rd == exp, req, "read data", 32'(rd), 32'(exp));
    endtask

    task automatic do_oow(input int a, input logic rw);
        logic [15:0] rd; logic [1:0] oe; logic ga, ge; int lat;
        access(rw, a, 1'b1, 1'b1, 16'hDEAD, 1'b0, "R6", rd, oe, ga, ge, lat);
        chk(!ga && ge, "R6", "out of window -> berr", 32'({ga, ge}), 32'h1);
        chk(oe == 2'b00, "R6", "no drive on berr", 32'(oe), 0);
        chk(lat == LAT, "R10", "berr latency", 32'(lat), 32'(LAT));
    endtask

    initial begin
        int sticky;
        for (int i = 0; i < DEPTH; i++) mdl[i] = 16'h0000;
        repeat (3) @(negedge clk);
        chk(ack_n && berr_n && data_oe == 2'b00, "R1", "reset outputs",
            32'({ack_n, berr_n, data_oe}), 32'hC);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ack_n && berr_n, "R1", "idle after reset", 32'({ack_n, berr_n}), 32'h3);

        // R1: memory cleared
        for (int i = 0; i < DEPTH; i += 5) do_read(i, 1'b1, 1'b1, 1'b0, "R1");

        // R3 R9: word writes across whole window
        for (int i = 0; i < DEPTH; i++) do_write(i, 1'b1, 1'b1, pat(i), 1'b0, "R9");
        // R2 R9: word, upper and lower reads
        for (int i = 0; i < DEPTH; i++) begin
            do_read(i, 1'b1, 1'b1, 1'b0, "R9");
            do_read(i, 1'b1, 1'b0, 1'b0, "R2");
            do_read(i, 1'b0, 1'b1, 1'b0, "R2");
        end
        // R3: single-lane writes keep the other byte
        for (int i = 0; i < DEPTH; i++) begin
            if (i % 2 == 0) do_write(i, 1'b1, 1'b0, 16'(32'h7700 + i * 32'h0311), 1'b0, "R3");
            else            do_write(i, 1'b0, 1'b1, 16'(32'h0066 + i * 32'h0113), 1'b0, "R3");
        end
        for (int i = 0; i < DEPTH; i++) do_read(i, 1'b1, 1'b1, 1'b0, "R3");

        // R5: read-modify-write with address strobe held
        do_read(5, 1'b0, 1'b1, 1'b1, "R5");
        chk(as_n == 1'b0, "R5", "strobe held", 32'(as_n), 0);
        do_write(5, 1'b0, 1'b1, 16'h00C4, 1'b1, "R5");
        do_read(5, 1'b1, 1'b1, 1'b1, "R5");
        as_n = 1'b1;
        @(negedge clk);
        do_read(5, 1'b1, 1'b1, 1'b0, "R5");

        // R6: below and above window
        do_oow(BASE - 1, 1'b0);
        do_oow(BASE + DEPTH, 1'b0);
        do_oow(BASE + DEPTH, 1'b1);
        do_oow(0, 1'b1);
        do_read(0, 1'b1, 1'b1, 1'b0, "R6");
        do_read(DEPTH - 1, 1'b1, 1'b1, 1'b0, "R6");

        // R8: skipped function code
        func_code = 3'b111;
        as_n = 1'b0; rd_wr = 1'b0; bus_addr = ADDR_W'(BASE + 3);
        data_in = 16'hFFFF; uds_n = 1'b0; lds_n = 1'b0;
        sticky = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (!ack_n || !berr_n) sticky = 1;
        end
        chk(sticky == 0, "R8", "no response to skipped code", 32'(sticky), 0);
        uds_n = 1'b1; lds_n = 1'b1; as_n = 1'b1; rd_wr = 1'b1;
        func_code = 3'b001;
        @(negedge clk);
        do_read(3, 1'b1, 1'b1, 1'b0, "R8");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog R10 actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule